// File: doc/BRIEF.md
# Dual Reference Selector with Activity Monitors

This block sits in front of a phase-locked loop on a line card and chooses which of two incoming reference clocks the loop follows. Each reference is brought into the local oscillator domain through a two-stage synchronizer. Each one then feeds its own activity monitor, which declares the input dead when no rising edge arrives within a programmable number of local cycles. A sticky per-input flag records every loss event until software clears it with a write-one-to-clear strobe.

One external select pin picks the active input. The block ignores that pin until a fixed power-on initialization window, counted in local cycles, has run out; until then the first input is always the one in use. The pin is expected to stay high for the whole window, and any low level seen during it sets a sticky init-error flag that only a reset removes. The alarm output reflects only the input currently in use. A holdover request tells the loop to freeze its frequency while that input is dead. The request drops on the first cycle that activity is seen again, with no qualification period.

Top module: `refsel_top`

## Requirements
- R1: While the active-low reset is asserted, sel_idx is 0, los_out is 1, hold_req is 0, dead_flag is 2'b00 and init_err is 0.
- R2: An input becomes active on the local cycle after its synchronized rising edge is seen (two synchronizer stages plus one edge-detect stage), and becomes inactive once TIMEOUT_CYC local cycles pass without a rising edge.
- R3: sel_idx is 0 (first input, ref_a) until INIT_CYC local cycles after reset release. After that it follows the select pin, delayed by two synchronizer stages and one register: pin high gives 0 (ref_a), pin low gives 1 (ref_b).
- R4: If the synchronized select pin is low in any cycle of the initialization window, init_err sets to 1 and stays 1 until the next reset.
- R5: los_out is 1 exactly when the input indexed by sel_idx is inactive. Loss of the other input leaves los_out unchanged.
- R6: hold_req is 1 when the initialization window has ended and the selected input is inactive. It returns to 0 in the same cycle that input turns active again.
- R7: dead_flag[i] (bit 0 for ref_a, bit 1 for ref_b) sets to 1 in the cycle input i goes from active to inactive. It stays set until a cycle with clr_flags[i] high and no new loss event. A loss event in the same cycle as a clear leaves the flag set.
- R8: ref_out carries ref_a when sel_idx is 0 and ref_b when sel_idx is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lo | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| ref_a | input | 1 | First reference clock (index 0) |
| ref_b | input | 1 | Second reference clock (index 1) |
| sel_pin | input | 1 | Input select: high picks ref_a, low picks ref_b |
| clr_flags | input | 2 | Write-one-to-clear strobe for dead_flag bits |
| ref_out | output | 1 | Selected reference clock to the loop |
| sel_idx | output | 1 | Index of the selected input |
| los_out | output | 1 | Loss of activity on the selected input |
| hold_req | output | 1 | Holdover (frequency freeze) request to the loop |
| dead_flag | output | 2 | Sticky per-input loss flags |
| init_err | output | 1 | Sticky flag: select pin low during initialization |

## Verification
Two things can land on the same edge. One is a loss event on an input together with a clear strobe for its flag. The other is a change of selection together with a change in the newly selected input's activity. The bench drives the first by holding the clear strobe high across the cycle where an input's timeout runs out. It drives the second by moving the select pin while one reference is stopped, so the alarm and holdover outputs must switch to the other input's state on the edge that moves the index. A behavioural model, stepped every local cycle, predicts each output on every cycle, and any mismatch is reported against its requirement.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int NUM_REFS = 2;

    typedef enum logic {
        PICK_FIRST  = 1'b0,
        PICK_SECOND = 1'b1
    } pick_e;

    typedef struct packed {
        pick_e                sel;
        logic [NUM_REFS-1:0]  flag;
        logic                 err;
    } top_state_t;
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic st1;
        logic st2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = din;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{st1: RST_VAL, st2: RST_VAL};
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.st2;
endmodule

// File: rtl/refsel_actmon.sv
module refsel_actmon #(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic active_o,
    output logic loss_o
);
    localparam int TCW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [TCW-1:0] LAST = TCW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic           prev;
        logic [TCW-1:0] cnt;
        logic           act;
    } mon_t;

    mon_t mon_d, mon_q;
    logic ref_s;
    logic rise;

    refsel_sync #(.RST_VAL(1'b0)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ref_i),
        .dout (ref_s)
    );

    assign rise = ref_s & ~mon_q.prev;

    always_comb begin
        mon_d      = mon_q;
        mon_d.prev = ref_s;
        loss_o     = 1'b0;
        if (rise) begin
            mon_d.cnt = '0;
            mon_d.act = 1'b1;
        end else if (mon_q.cnt == LAST) begin
            mon_d.act = 1'b0;
            loss_o    = mon_q.act;
        end else begin
            mon_d.cnt = mon_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign active_o = mon_q.act;
endmodule

// File: rtl/refsel_initgate.sv
module refsel_initgate #(
    parameter int INIT_CYC = 3212800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_s_o,
    output logic done_o
);
    localparam int ICW = $clog2(INIT_CYC + 1);
    localparam logic [ICW-1:0] END_CNT = ICW'(INIT_CYC);

    typedef struct packed {
        logic [ICW-1:0] cnt;
    } gate_t;

    gate_t gate_d, gate_q;

    refsel_sync #(.RST_VAL(1'b1)) i_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_i),
        .dout (pin_s_o)
    );

    assign done_o = (gate_q.cnt == END_CNT);

    always_comb begin
        gate_d = gate_q;
        if (!done_o) gate_d.cnt = gate_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int INIT_CYC    = 3212800
) (
    input  logic       clk_lo,
    input  logic       rst_n,
    input  logic       ref_a,
    input  logic       ref_b,
    input  logic       sel_pin,
    input  logic [1:0] clr_flags,
    output logic       ref_out,
    output logic       sel_idx,
    output logic       los_out,
    output logic       hold_req,
    output logic [1:0] dead_flag,
    output logic       init_err
);
    logic [NUM_REFS-1:0] refs;
    logic [NUM_REFS-1:0] act;
    logic [NUM_REFS-1:0] loss;
    logic                pin_s;
    logic                init_done;

    top_state_t st_d, st_q;

    assign refs = {ref_b, ref_a};

    for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_mon
        refsel_actmon #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_mon (
            .clk     (clk_lo),
            .rst_n   (rst_n),
            .ref_i   (refs[gi]),
            .active_o(act[gi]),
            .loss_o  (loss[gi])
        );
    end

    refsel_initgate #(.INIT_CYC(INIT_CYC)) i_gate (
        .clk    (clk_lo),
        .rst_n  (rst_n),
        .pin_i  (sel_pin),
        .pin_s_o(pin_s),
        .done_o (init_done)
    );

    always_comb begin
        st_d      = st_q;
        // selection held on the first input until the window ends
        st_d.sel  = init_done ? (pin_s ? PICK_FIRST : PICK_SECOND) : PICK_FIRST;
        st_d.err  = st_q.err | (~init_done & ~pin_s);
        // loss event wins over a clear in the same cycle
        st_d.flag = loss | (st_q.flag & ~clr_flags);
    end

    always_ff @(posedge clk_lo or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: PICK_FIRST, flag: '0, err: 1'b0};
        else        st_q <= st_d;
    end

    assign sel_idx   = st_q.sel;
    assign ref_out   = st_q.sel ? ref_b : ref_a;
    assign los_out   = ~act[st_q.sel];
    assign hold_req  = init_done & ~act[st_q.sel];
    assign dead_flag = st_q.flag;
    assign init_err  = st_q.err;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk (
    input logic       clk_lo,
    input logic       rst_n,
    input logic       sel_idx,
    input logic       los_out,
    input logic       hold_req,
    input logic [1:0] dead_flag,
    input logic [1:0] clr_flags,
    input logic       init_err,
    input logic       init_done,
    input logic [1:0] act
);
    a_r3_first_until_init: assert property (@(posedge clk_lo) disable iff (!rst_n)
        !init_done |-> (sel_idx == 1'b0));

    a_r3_change_after_init: assert property (@(posedge clk_lo) disable iff (!rst_n)
        (sel_idx != $past(sel_idx)) |-> init_done);

    a_r4_err_sticky: assert property (@(posedge clk_lo) disable iff (!rst_n)
        init_err |=> init_err);

    a_r6_hold_needs_los: assert property (@(posedge clk_lo) disable iff (!rst_n)
        hold_req |-> los_out);

    a_r7_flag0_keep: assert property (@(posedge clk_lo) disable iff (!rst_n)
        (dead_flag[0] && !clr_flags[0]) |=> dead_flag[0]);

    a_r7_flag1_keep: assert property (@(posedge clk_lo) disable iff (!rst_n)
        (dead_flag[1] && !clr_flags[1]) |=> dead_flag[1]);

    a_r7_fall0_sets: assert property (@(posedge clk_lo) disable iff (!rst_n)
        $fell(act[0]) |-> dead_flag[0]);

    a_r7_fall1_sets: assert property (@(posedge clk_lo) disable iff (!rst_n)
        $fell(act[1]) |-> dead_flag[1]);
endmodule

bind refsel_top refsel_chk i_chk (
    .clk_lo   (clk_lo),
    .rst_n    (rst_n),
    .sel_idx  (sel_idx),
    .los_out  (los_out),
    .hold_req (hold_req),
    .dead_flag(dead_flag),
    .clr_flags(clr_flags),
    .init_err (init_err),
    .init_done(init_done),
    .act      (act)
);

// File: tb/test_refsel_top.sv
module test_refsel_top;
    localparam int CLK_PERIOD = 10;
    localparam int TO_CYC     = 8;
    localparam int INIT_C     = 40;

    logic       clk_lo = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_a = 1'b0;
    logic       ref_b = 1'b0;
    logic       sel_pin = 1'b1;
    logic [1:0] clr_flags = 2'b00;
    logic       ref_out, sel_idx, los_out, hold_req, init_err;
    logic [1:0] dead_flag;

    int total = 0;
    int bad = 0;
    int half_a = 0, half_b = 0, cnt_a = 0, cnt_b = 0;

    // model state
    int m_s1[2], m_s2[2], m_s3[2], m_cnt[2], m_act[2], m_flag[2];
    int m_p1, m_p2, m_ic, m_err, m_sel;

    always #(CLK_PERIOD/2) clk_lo = ~clk_lo;

    refsel_top #(.TIMEOUT_CYC(TO_CYC), .INIT_CYC(INIT_C)) i_refsel_top (
        .clk_lo(clk_lo), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
        .sel_pin(sel_pin), .clr_flags(clr_flags), .ref_out(ref_out),
        .sel_idx(sel_idx), .los_out(los_out), .hold_req(hold_req),
        .dead_flag(dead_flag), .init_err(init_err)
    );

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
            m_cnt[i] = 0; m_act[i] = 0; m_flag[i] = 0;
        end
        m_p1 = 1; m_p2 = 1; m_ic = 0; m_err = 0; m_sel = 0;
    endtask

    always @(posedge clk_lo) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int rin[2];
            int loss;
            int old_done;
            rin[0] = ref_a; rin[1] = ref_b;
            for (int i = 0; i < 2; i++) begin
                loss = 0;
                if (m_s2[i] == 1 && m_s3[i] == 0) begin
                    m_cnt[i] = 0; m_act[i] = 1;
                end else if (m_cnt[i] == TO_CYC - 1) begin
                    if (m_act[i] == 1) loss = 1;
                    m_act[i] = 0;
                end else begin
                    m_cnt[i]++;
                end
                m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = rin[i];
                if (loss == 1) m_flag[i] = 1;
                else if ((clr_flags[i]) == 1'b1) m_flag[i] = 0;
            end
            old_done = (m_ic >= INIT_C) ? 1 : 0;
            if (old_done == 0 && m_p2 == 0) m_err = 1;
            m_sel = (old_done == 1) ? ((m_p2 == 1) ? 0 : 1) : 0;
            m_p2 = m_p1; m_p1 = sel_pin;
            if (old_done == 0) m_ic++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic compare_all();
        int e_los, e_hold, e_ref, done;
        done   = (m_ic >= INIT_C) ? 1 : 0;
        e_los  = (m_act[m_sel] == 0) ? 1 : 0;
        e_hold = (done == 1 && e_los == 1) ? 1 : 0;
        e_ref  = (m_sel == 1) ? int'(ref_b) : int'(ref_a);
        chk(int'(sel_idx) == m_sel, "R3 sel_idx", sel_idx, m_sel);
        chk(int'(init_err) == m_err, "R4 init_err", init_err, m_err);
        chk(int'(los_out) == e_los, "R2/R5 los_out", los_out, e_los);
        chk(int'(hold_req) == e_hold, "R6 hold_req", hold_req, e_hold);
        chk(int'(dead_flag[0]) == m_flag[0], "R7 dead_flag[0]", dead_flag[0], m_flag[0]);
        chk(int'(dead_flag[1]) == m_flag[1], "R7 dead_flag[1]", dead_flag[1], m_flag[1]);
        chk(int'(ref_out) == e_ref, "R8 ref_out", ref_out, e_ref);
    endtask

    // one local cycle: check at negedge, then advance reference clocks
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk_lo);
            if (rst_n) compare_all();
            if (half_a > 0) begin
                cnt_a++;
                if (cnt_a >= half_a) begin cnt_a = 0; ref_a = ~ref_a; end
            end
            if (half_b > 0) begin
                cnt_b++;
                if (cnt_b >= half_b) begin cnt_b = 0; ref_b = ~ref_b; end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        half_a = 2; half_b = 3;
        @(negedge clk_lo);
        @(negedge clk_lo);
        // R1 reset state
        chk(sel_idx == 1'b0, "R1 sel_idx in reset", sel_idx, 0);
        chk(los_out == 1'b1, "R1 los_out in reset", los_out, 1);
        chk(hold_req == 1'b0, "R1 hold_req in reset", hold_req, 0);
        chk(dead_flag == 2'b00, "R1 dead_flag in reset", dead_flag, 0);
        chk(init_err == 1'b0, "R1 init_err in reset", init_err, 0);
        rst_n = 1'b1;
        step(60);
        chk(sel_idx == 1'b0 && los_out == 1'b0, "R3 first input after init", sel_idx, 0);
        chk(init_err == 1'b0, "R4 no error with pin high", init_err, 0);

        sel_pin = 1'b0;
        step(30);
        chk(sel_idx == 1'b1, "R3 pin low selects second", sel_idx, 1);

        // selected input stops: alarm, holdover, flag
        half_b = 0;
        step(30);
        chk(los_out == 1'b1 && hold_req == 1'b1, "R6 holdover on selected loss", hold_req, 1);
        chk(dead_flag == 2'b10, "R7 flag of second set", dead_flag, 2);
        half_b = 3;
        step(20);
        chk(hold_req == 1'b0 && los_out == 1'b0, "R6 holdover released", hold_req, 0);

        // unselected input stops
        half_a = 0;
        step(20);
        chk(los_out == 1'b0, "R5 unselected loss leaves los_out", los_out, 0);
        chk(dead_flag == 2'b11, "R7 flag of first set", dead_flag, 3);

        // selection moves onto the dead input
        sel_pin = 1'b1;
        step(10);
        chk(sel_idx == 1'b0 && los_out == 1'b1, "R5 los follows new selection", los_out, 1);
        sel_pin = 1'b0;
        step(10);

        // clear both flags
        clr_flags = 2'b11;
        step(1);
        clr_flags = 2'b00;
        step(5);
        chk(dead_flag == 2'b00, "R7 write-one-to-clear", dead_flag, 0);

        // clear held across a fresh loss event on the first input
        half_a = 2;
        step(20);
        half_a = 0;
        clr_flags = 2'b01;
        step(25);
        clr_flags = 2'b00;
        step(3);
        chk(dead_flag[0] == 1'b0, "R7 flag after overlapped clear", dead_flag[0], 0);
        half_a = 2;
        step(20);

        // second reset with misuse of the pin in the window
        rst_n = 1'b0;
        sel_pin = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(5);
        sel_pin = 1'b1;
        step(INIT_C + 10);
        chk(init_err == 1'b1, "R4 init error sticky", init_err, 1);
        chk(sel_idx == 1'b0, "R3 pin high after window", sel_idx, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule